// File: doc/BRIEF.md
# TDM Transmit Slot Serializer

This block is the transmit half of a time-division-multiplexed audio port. Sample words are written into a 32-entry first-in first-out buffer. The block takes one word at the start of each active slot of a frame and shifts it out most significant bit first on a single serial line. An external frame generator supplies a bit strobe, which is a one-cycle clock enable per serial bit, and a frame strobe that marks the first bit of slot 0. The block does its own counting of bits within a slot and of slots within a frame.

Word length and slot length are set separately. A word shorter than its slot sits at either end of the slot, and the bits around it are zero. A word longer than its slot is cut down to its most significant bits. The number of active slots per frame is programmable, and any slot past that count sends zeros. A request output asks for refill when the buffer level drops to half or to a quarter of its depth. If an active slot starts while the buffer is empty, the block sends a zero sample and raises a sticky underflow flag.

Top module: `tdmtx_serializer`

## Requirements
- R1: Word length code `cfg_wlen` selects 8, 16, 20, 24 or 32 bits for codes 0, 1, 2, 3, 4; codes 5 to 7 select 32 bits. Only the low word-length bits of a sample are transmitted.
- R2: Slot length code `cfg_slen` selects 8, 16 or 32 bit periods for codes 0, 1, 2; code 3 selects 32.
- R3: Slots 0 to `cfg_slots`-1 of each frame carry samples. Slots numbered `cfg_slots` or higher, up to the next frame strobe, drive 0.
- R4: With `cfg_left`=1 the word fills the first bits of its slot. With `cfg_left`=0 the word fills the last bits of its slot. All other bits of the slot are 0. A word longer than its slot sends only its top slot-length bits, and this holds in both justification modes.
- R5: Data leaves MSB first, one bit per bit strobe. `sdo` changes only on a clock edge at which `bit_stb` is high. A strobe that has `frame_stb` high carries the first bit of slot 0.
- R6: The buffer keeps write order and holds 32 words. `wr_full` is high at 32 words, and a write while full is dropped.
- R7: `fifo_req` is high when the level is at or below 16 with `cfg_quarter`=0, and at or below 8 with `cfg_quarter`=1.
- R8: While `tx_en` is low, `sdo` drives 0 at every bit strobe and no word is taken from the buffer.
- R9: An active slot that starts with the buffer empty sends 0 and sets `underflow`. The flag stays set while `tx_en` stays high and clears one clock after `tx_en` goes low.
- R10: After reset `sdo`=0, `underflow`=0, `wr_full`=0, `fifo_req`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write one sample into the buffer |
| wr_data | input | 32 | Sample to write, word right-aligned |
| wr_full | output | 1 | Buffer holds 32 words |
| tx_en | input | 1 | Transmit enable |
| cfg_wlen | input | 3 | Word length code |
| cfg_slen | input | 2 | Slot length code |
| cfg_slots | input | 4 | Active slots per frame |
| cfg_left | input | 1 | 1 places the word first in the slot, 0 places it last |
| cfg_quarter | input | 1 | Request threshold: 0 half, 1 quarter |
| bit_stb | input | 1 | One-cycle strobe per serial bit |
| frame_stb | input | 1 | Marks the first bit of a frame, high together with bit_stb |
| sdo | output | 1 | Serial data out |
| fifo_req | output | 1 | Buffer level at or below threshold |
| underflow | output | 1 | Sticky: a slot started with the buffer empty |

## Verification
The bench uses the default 32-bit sample width and 32-entry depth. With these values both request thresholds (8 and 16) can be reached, and so can the full state at 32 with a dropped 33rd write. The 32-bit width allows a full-length word to be placed in a 16-bit slot to test truncation. The 4-bit slot counter allows frames longer than the active slot count, so the trailing zero slots can be observed.

// File: rtl/tdmtx_pkg.sv
package tdmtx_pkg;

  localparam int LEN_W = 6;

  // Word length code to bit count (codes above 4 give the full 32 bits).
  function automatic logic [LEN_W-1:0] word_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 6'd8;
      3'd1:    return 6'd16;
      3'd2:    return 6'd20;
      3'd3:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  // Slot length code to bit periods.
  function automatic logic [LEN_W-1:0] slot_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd8;
      2'd1:    return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/tdmtx_fifo.sv
module tdmtx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);

  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_n, rd_ptr_n;
  logic [LW-1:0] lvl_n;
  logic          do_push, do_pop;

  assign full    = (level == FULL_LVL);
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    lvl_n    = level;
    if (do_push) wr_ptr_n = wr_ptr + 1'b1;
    if (do_pop)  rd_ptr_n = rd_ptr + 1'b1;
    case ({do_push, do_pop})
      2'b10:   lvl_n = level + 1'b1;
      2'b01:   lvl_n = level - 1'b1;
      default: lvl_n = level;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      level  <= lvl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

endmodule

// File: rtl/tdmtx_slot_timer.sv
module tdmtx_slot_timer #(
  parameter int SLOT_CW = 4,
  localparam int LEN_W  = tdmtx_pkg::LEN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_stb,
  input  logic               frame_stb,
  input  logic               tx_en,
  input  logic [LEN_W-1:0]   sbits,
  input  logic [SLOT_CW-1:0] nslots,
  output logic               live,
  output logic               start
);

  localparam logic [SLOT_CW-1:0] SLOT_MAX = '1;

  logic [LEN_W-1:0]   bit_cnt, bit_n;
  logic [SLOT_CW-1:0] slot_idx, slot_n;
  logic               in_frame, in_frame_n;

  // Position of the bit carried by the current strobe.
  always_comb begin
    bit_n      = bit_cnt + 1'b1;
    slot_n     = slot_idx;
    in_frame_n = in_frame;
    if (frame_stb) begin
      bit_n      = '0;
      slot_n     = '0;
      in_frame_n = 1'b1;
    end else if (bit_n == sbits) begin
      bit_n  = '0;
      slot_n = (slot_idx == SLOT_MAX) ? slot_idx : slot_idx + 1'b1;
    end
  end

  assign live  = bit_stb && in_frame_n && tx_en && (slot_n < nslots);
  assign start = live && (bit_n == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      slot_idx <= '0;
      in_frame <= 1'b0;
    end else if (bit_stb) begin
      bit_cnt  <= bit_n;
      slot_idx <= slot_n;
      in_frame <= in_frame_n;
    end
  end

endmodule

// File: rtl/tdmtx_shifter.sv
module tdmtx_shifter #(
  parameter int DW     = 32,
  localparam int LEN_W = tdmtx_pkg::LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             live,
  input  logic             start,
  input  logic [DW-1:0]    sample,
  input  logic             sample_ok,
  input  logic [LEN_W-1:0] wbits,
  input  logic [LEN_W-1:0] sbits,
  input  logic             left,
  output logic             sdo,
  output logic             uf_set
);

  localparam logic [LEN_W-1:0] FULL_W = LEN_W'(DW);

  logic [DW-1:0]    word_top, slot_img, sh, sh_n;
  logic [LEN_W-1:0] pad;
  logic             sdo_n;

  // Word pushed to the top, then moved down by the pad for right justify.
  always_comb begin
    word_top = sample << (FULL_W - wbits);
    pad      = (!left && (sbits > wbits)) ? (sbits - wbits) : '0;
    slot_img = sample_ok ? (word_top >> pad) : '0;
  end

  assign uf_set = start && !sample_ok;

  always_comb begin
    sdo_n = sdo;
    sh_n  = sh;
    if (bit_stb) begin
      if (start) begin
        sdo_n = slot_img[DW-1];
        sh_n  = slot_img << 1;
      end else if (live) begin
        sdo_n = sh[DW-1];
        sh_n  = sh << 1;
      end else begin
        sdo_n = 1'b0;
        sh_n  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo <= 1'b0;
      sh  <= '0;
    end else begin
      sdo <= sdo_n;
      sh  <= sh_n;
    end
  end

endmodule

// File: rtl/tdmtx_serializer.sv
module tdmtx_serializer #(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 32,
  parameter int SLOT_CW    = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               wr_full,
  input  logic               tx_en,
  input  logic [2:0]         cfg_wlen,
  input  logic [1:0]         cfg_slen,
  input  logic [SLOT_CW-1:0] cfg_slots,
  input  logic               cfg_left,
  input  logic               cfg_quarter,
  input  logic               bit_stb,
  input  logic               frame_stb,
  output logic               sdo,
  output logic               fifo_req,
  output logic               underflow
);

  import tdmtx_pkg::*;

  localparam logic [LVL_W-1:0] THR_HALF    = LVL_W'(FIFO_DEPTH / 2);
  localparam logic [LVL_W-1:0] THR_QUARTER = LVL_W'(FIFO_DEPTH / 4);

  logic              rst_meta_n, rst_sync_n;
  logic              slot_pop, slot_live, fifo_empty, uf_set, uf_n;
  logic [DATA_W-1:0] head;
  logic [LVL_W-1:0]  fifo_level;
  logic [LEN_W-1:0]  wbits, sbits;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign wbits = word_bits(cfg_wlen);
  assign sbits = slot_bits(cfg_slen);

  tdmtx_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (wr_en),
    .wdata (wr_data),
    .pop   (slot_pop),
    .rdata (head),
    .empty (fifo_empty),
    .full  (wr_full),
    .level (fifo_level)
  );

  tdmtx_slot_timer #(.SLOT_CW(SLOT_CW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bit_stb   (bit_stb),
    .frame_stb (frame_stb),
    .tx_en     (tx_en),
    .sbits     (sbits),
    .nslots    (cfg_slots),
    .live      (slot_live),
    .start     (slot_pop)
  );

  tdmtx_shifter #(.DW(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bit_stb   (bit_stb),
    .live      (slot_live),
    .start     (slot_pop),
    .sample    (head),
    .sample_ok (!fifo_empty),
    .wbits     (wbits),
    .sbits     (sbits),
    .left      (cfg_left),
    .sdo       (sdo),
    .uf_set    (uf_set)
  );

  assign fifo_req = (fifo_level <= (cfg_quarter ? THR_QUARTER : THR_HALF));

  always_comb begin
    uf_n = tx_en ? (underflow || uf_set) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) underflow <= 1'b0;
    else             underflow <= uf_n;
  end

endmodule

// File: rtl/tdmtx_serializer_chk.sv
module tdmtx_serializer_chk #(
  parameter int FIFO_DEPTH = 32,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_full,
  input logic             tx_en,
  input logic             bit_stb,
  input logic             sdo,
  input logic             fifo_req,
  input logic             underflow,
  input logic             pop,
  input logic [LVL_W-1:0] level
);

  assert_sdo_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(sdo));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && bit_stb) |=> !sdo);

  assert_idle_no_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !pop);

  assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_full && wr_en && !pop) |=> $stable(level));

  assert_req_not_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_req |-> !wr_full);

  assert_uf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && tx_en) |=> underflow);

  assert_uf_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !underflow);

endmodule

bind tdmtx_serializer tdmtx_serializer_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .wr_full   (wr_full),
  .tx_en     (tx_en),
  .bit_stb   (bit_stb),
  .sdo       (sdo),
  .fifo_req  (fifo_req),
  .underflow (underflow),
  .pop       (slot_pop),
  .level     (fifo_level)
);

// File: tb/tdmtx_serializer_test.sv
`timescale 1ns/1ps
module tdmtx_serializer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        wr_full;
  logic        tx_en;
  logic [2:0]  cfg_wlen;
  logic [1:0]  cfg_slen;
  logic [3:0]  cfg_slots;
  logic        cfg_left;
  logic        cfg_quarter;
  logic        bit_stb;
  logic        frame_stb;
  logic        sdo;
  logic        fifo_req;
  logic        underflow;

  int n_tests = 0;
  int n_fail  = 0;
  int cur_wl, cur_sl;
  logic [31:0] exp_q [$];

  always #4 clk = ~clk;

  tdmtx_serializer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .tx_en(tx_en), .cfg_wlen(cfg_wlen), .cfg_slen(cfg_slen), .cfg_slots(cfg_slots),
    .cfg_left(cfg_left), .cfg_quarter(cfg_quarter), .bit_stb(bit_stb),
    .frame_stb(frame_stb), .sdo(sdo), .fifo_req(fifo_req), .underflow(underflow)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int wl_of(input int code);
    case (code)
      0: return 8; 1: return 16; 2: return 20; 3: return 24; default: return 32;
    endcase
  endfunction

  function automatic int sl_of(input int code);
    case (code)
      0: return 8; 1: return 16; default: return 32;
    endcase
  endfunction

  // Expected slot contents, first transmitted bit at position sl-1.
  function automatic logic [31:0] exp_slot(input logic [31:0] s, input int wl,
                                           input int sl, input bit left);
    logic [31:0] r = '0;
    int pad = (!left && sl > wl) ? sl - wl : 0;
    for (int i = 0; i < sl; i++)
      if (i >= pad && (i - pad) < wl) r[sl-1-i] = s[wl-1-(i-pad)];
    return r;
  endfunction

  task automatic set_cfg(input int wcode, input int scode, input int slots, input bit left);
    @(negedge clk);
    cfg_wlen  = 3'(wcode);
    cfg_slen  = 2'(scode);
    cfg_slots = 4'(slots);
    cfg_left  = left;
    cur_wl    = wl_of(wcode);
    cur_sl    = sl_of(scode);
  endtask

  // Driver: writes the buffer and records what the design should hold.
  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = w;
    if (exp_q.size() < 32) exp_q.push_back(w);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Monitor: strobes one frame, gathers each slot and compares with the scoreboard.
  task automatic run_frame(input string tag, input int total_slots);
    for (int s = 0; s < total_slots; s++) begin
      logic [31:0] got = '0;
      logic [31:0] exp = '0;
      for (int b = 0; b < cur_sl; b++) begin
        @(negedge clk);
        bit_stb   = 1'b1;
        frame_stb = (s == 0 && b == 0);
        @(negedge clk);
        bit_stb   = 1'b0;
        frame_stb = 1'b0;
        got = {got[30:0], sdo};
      end
      if (tx_en && s < int'(cfg_slots) && exp_q.size() > 0)
        exp = exp_slot(exp_q.pop_front(), cur_wl, cur_sl, cfg_left);
      check(tag, $sformatf("slot %0d", s), got, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R5 watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; tx_en = 1'b0;
    cfg_wlen = 3'd1; cfg_slen = 2'd1; cfg_slots = 4'd2; cfg_left = 1'b1;
    cfg_quarter = 1'b0; bit_stb = 1'b0; frame_stb = 1'b0;
    cur_wl = 16; cur_sl = 16;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R10", "sdo", 32'(sdo), 32'd0);
    check("R10", "underflow", 32'(underflow), 32'd0);
    check("R10", "wr_full", 32'(wr_full), 32'd0);
    check("R10", "fifo_req", 32'(fifo_req), 32'd1);

    // R5: 16-bit words in 16-bit slots, two frames, MSB first
    set_cfg(1, 1, 2, 1'b1);
    tx_en = 1'b1;
    push_word(32'h0000_A5C3); push_word(32'h0000_8001);
    push_word(32'h0000_1234); push_word(32'h0000_FFFE);
    run_frame("R5", 2);
    run_frame("R5", 2);

    // R4: 24-bit word right-justified in 32-bit slot; R3: two extra slots stay zero
    set_cfg(3, 2, 4, 1'b0);
    for (int i = 0; i < 4; i++) push_word(32'hAB00_0000 | (32'h00C3_5A17 + 32'(i * 32'h1111)));
    run_frame("R4", 6);

    // R3: one active slot of 8-bit word left in 32-bit slot, then zeros
    set_cfg(0, 2, 1, 1'b1);
    push_word(32'h1234_5696);
    run_frame("R3", 3);

    // R4: 32-bit word into 16-bit slot keeps top bits, both justify modes
    set_cfg(4, 1, 1, 1'b1);
    push_word(32'hDEAD_BEEF);
    run_frame("R4", 1);
    set_cfg(4, 1, 1, 1'b0);
    push_word(32'h8765_4321);
    run_frame("R4", 1);

    // R1: 20-bit words right-justified, 6 slots of 32
    set_cfg(2, 2, 6, 1'b0);
    for (int i = 0; i < 6; i++) push_word(32'hFFF0_0000 | 32'(32'h9_A5F1 ^ (i * 32'h3_0303)));
    run_frame("R1", 6);

    // R8: disabled transmit sends zeros and consumes nothing
    set_cfg(1, 1, 2, 1'b1);
    push_word(32'h0000_C0DE); push_word(32'h0000_5A5A);
    tx_en = 1'b0;
    run_frame("R8", 2);
    tx_en = 1'b1;
    run_frame("R8", 2);

    // R9: empty buffer sends zero and sets sticky flag
    run_frame("R9", 2);
    check("R9", "underflow set", 32'(underflow), 32'd1);
    repeat (3) @(negedge clk);
    check("R9", "underflow held", 32'(underflow), 32'd1);
    tx_en = 1'b0;
    @(negedge clk);
    check("R9", "underflow cleared", 32'(underflow), 32'd0);

    // R7: thresholds
    cfg_quarter = 1'b1;
    for (int i = 0; i < 8; i++) push_word(32'h0000_0010 + 32'(i));
    check("R7", "quarter at 8", 32'(fifo_req), 32'd1);
    push_word(32'h0000_0018);
    check("R7", "quarter at 9", 32'(fifo_req), 32'd0);
    cfg_quarter = 1'b0;
    @(negedge clk);
    check("R7", "half at 9", 32'(fifo_req), 32'd1);
    for (int i = 0; i < 7; i++) push_word(32'h0000_0019 + 32'(i));
    check("R7", "half at 16", 32'(fifo_req), 32'd1);
    push_word(32'h0000_0020);
    check("R7", "half at 17", 32'(fifo_req), 32'd0);

    // R6: fill, drop one write while full, drain in order
    for (int i = 0; i < 15; i++) push_word(32'h0000_0021 + 32'(i));
    check("R6", "full at 32", 32'(wr_full), 32'd1);
    push_word(32'h0000_00EE);
    check("R6", "still full", 32'(wr_full), 32'd1);

    // R2: 8-bit slots, 8 per frame drain all 32, then one underflow slot
    set_cfg(0, 0, 8, 1'b1);
    tx_en = 1'b1;
    for (int f = 0; f < 4; f++) run_frame("R2", 8);
    check("R6", "not full after drain", 32'(wr_full), 32'd0);
    run_frame("R6", 1);
    check("R9", "underflow after drain", 32'(underflow), 32'd1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule